// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic reach an external 16-bit asynchronous static RAM. The RAM has active-low select, output-enable and write-strobe pins, plus one active-low enable for each byte lane. The user side has a request/acknowledge port. The user presents an address, a direction flag, a two-bit lane mask and write data, and the block answers with a one-cycle acknowledge. On reads it also returns the data and a valid strobe.

The memory's timing limits are parameters given in nanoseconds, together with the clock period. At elaboration each limit becomes a whole number of clock cycles, rounded up, with a floor of one cycle. The block also enforces a 100 µs settling delay after reset before the first access. It controls the shared data bus through separate output, input and drive-enable signals, so the pad tri-state can sit outside the block.

Top module: `sram_ctl`

## Requirements
- R1: After reset is released, `req_ready` stays low for at least PU = ceil(POWERUP_NS / CLK_PERIOD_NS) cycles. It is first seen high after the (PU+1)-th rising edge.
- R2: A read holds `sram_ce_n`, `sram_oe_n` and the enabled lane strobes low for exactly RD cycles. RD is the largest of the rounded-up cycle-time, address-access, output-enable-access and byte-enable-access limits. The acknowledge follows RD+1 cycles after acceptance.
- R3: Read data is captured from `sram_dq_in` on the last cycle of the read. `rd_valid` is high together with `ack` only for reads with a nonzero mask. Mask bit 1 selects bits 15:8 through `sram_ub_n`, and mask bit 0 selects bits 7:0 through `sram_lb_n`. A disabled lane returns zero in `rd_data`.
- R4: A write (`req_write`=1) runs a setup phase of SU cycles with `sram_we_n` high. It then holds `sram_we_n` low for PW cycles and keeps it high for a recovery phase of REC cycles. PW covers the pulse-width, data-setup, select-to-end and address-to-end limits. REC stretches the total to the write-cycle limit and is at least 1 cycle.
- R5: The block drives the data bus only while `sram_we_n` is low and `sram_oe_n` is high. The value it drives is the accepted write data.
- R6: Each write ends on the rising edge of `sram_we_n`, while select and the enabled lane strobes are still low. The address does not change while select is low.
- R7: A request with an all-zero mask is acknowledged one cycle after acceptance. It never pulls select low and never changes memory contents.
- R8: `ack` is a single-cycle pulse. `req_ready` is high only while the block is idle.
- R9: `sram_oe_n` is never low in the cycle right after a cycle in which the bus was driven.
- R10: A write changes only the byte lanes enabled by its mask. The other lanes keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_mask | input | 2 | Lane mask, bit 1 high byte, bit 0 low byte |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read data valid, coincident with ack |
| rd_data | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Memory select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_ub_n | output | 1 | High-byte lane enable, active low |
| sram_lb_n | output | 1 | Low-byte lane enable, active low |
| sram_dq_out | output | 16 | Data toward memory |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_in | input | 16 | Data from memory |

## Verification
The hardest situation to reach is a partial-lane write that lands on a word already holding other data, followed by a read with a different mask. Only that combination shows whether lanes are merged correctly and masked on the way back. The stimulus first fills every word with a distinct full-width pattern. It then writes a second pattern to each word with a mask that rotates through all four values, including the empty one. Finally it reads every word with a second rotating mask. A bench-side memory model commits data only on the rising write-strobe edge, so a write that ends too early or with the wrong lanes shows up in the data read back.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_READ_WAIT,
        ST_WRITE_SETUP,
        ST_WRITE_PULSE,
        ST_WRITE_RECOVER,
        ST_DONE
    } state_e;

    // Rounded-up conversion of a nanosecond limit to clock cycles, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Remaining cycles after an already elapsed portion, never below one.
    function automatic int unsigned rest_cyc(input int unsigned total, input int unsigned used);
        return (total > used) ? (total - used) : 1;
    endfunction

endpackage

// File: rtl/sram_ctl_powerup.sv
module sram_ctl_powerup #(
    parameter int unsigned PU_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    output logic pu_done
);
    localparam int unsigned CW = $clog2(PU_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PU_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } pu_t;

    pu_t q, d;

    always_comb begin
        d = q;
        if (!q.done) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST) begin
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pu_done = q.done;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pu_done |=> pu_done); // R1

endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANES-1:0]        req_mask,
    output logic [LANES-1:0]        req_en_n,
    input  logic [LANES-1:0]        cur_en_n,
    input  logic [LANES*LANE_W-1:0] raw,
    output logic [LANES*LANE_W-1:0] masked
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign req_en_n[i] = ~req_mask[i];
        assign masked[i*LANE_W +: LANE_W] =
            cur_en_n[i] ? '0 : raw[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 18,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned LANES   = 2,
    parameter int unsigned RD_CYC  = 2,
    parameter int unsigned SU_CYC  = 1,
    parameter int unsigned PW_CYC  = 2,
    parameter int unsigned REC_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pu_done,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_en_n,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] rd_masked,
    output logic              ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_en_n,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] mem_dq_out
);
    localparam int unsigned TMAX = umax(umax(RD_CYC, SU_CYC), umax(PW_CYC, REC_CYC));
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] RD_T  = TW'(RD_CYC - 1);
    localparam logic [TW-1:0] SU_T  = TW'(SU_CYC - 1);
    localparam logic [TW-1:0] PW_T  = TW'(PW_CYC - 1);
    localparam logic [TW-1:0] REC_T = TW'(REC_CYC - 1);

    typedef struct packed {
        state_e            state;
        logic [TW-1:0]     timer;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  en_n;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              is_rd;
    } regs_t;

    localparam regs_t RST_VAL = '{
        state: ST_POWERUP,
        timer: '0,
        addr:  '0,
        en_n:  '1,
        ce_n:  1'b1,
        oe_n:  1'b1,
        we_n:  1'b1,
        dq_oe: 1'b0,
        wdata: '0,
        rdata: '0,
        is_rd: 1'b0
    };

    regs_t q, d;
    logic  tmr_zero;

    assign tmr_zero = (q.timer == '0);

    always_comb begin
        d = q;
        unique case (q.state)
            ST_POWERUP: begin
                if (pu_done) begin
                    d.state = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (req_valid) begin
                    if (&req_en_n) begin
                        d.state = ST_DONE;
                        d.is_rd = 1'b0;
                    end else begin
                        d.addr  = req_addr;
                        d.en_n  = req_en_n;
                        d.wdata = req_wdata;
                        d.ce_n  = 1'b0;
                        if (req_write) begin
                            d.state = ST_WRITE_SETUP;
                            d.timer = SU_T;
                            d.is_rd = 1'b0;
                        end else begin
                            d.state = ST_READ_WAIT;
                            d.timer = RD_T;
                            d.oe_n  = 1'b0;
                            d.is_rd = 1'b1;
                        end
                    end
                end
            end
            ST_READ_WAIT: begin
                if (tmr_zero) begin
                    d.rdata = rd_masked;
                    d.ce_n  = 1'b1;
                    d.oe_n  = 1'b1;
                    d.en_n  = '1;
                    d.state = ST_DONE;
                end else begin
                    d.timer = q.timer - 1'b1;
                end
            end
            ST_WRITE_SETUP: begin
                if (tmr_zero) begin
                    d.we_n  = 1'b0;
                    d.dq_oe = 1'b1;
                    d.timer = PW_T;
                    d.state = ST_WRITE_PULSE;
                end else begin
                    d.timer = q.timer - 1'b1;
                end
            end
            ST_WRITE_PULSE: begin
                if (tmr_zero) begin
                    d.we_n  = 1'b1;
                    d.dq_oe = 1'b0;
                    d.timer = REC_T;
                    d.state = ST_WRITE_RECOVER;
                end else begin
                    d.timer = q.timer - 1'b1;
                end
            end
            ST_WRITE_RECOVER: begin
                if (tmr_zero) begin
                    d.ce_n  = 1'b1;
                    d.en_n  = '1;
                    d.state = ST_DONE;
                end else begin
                    d.timer = q.timer - 1'b1;
                end
            end
            ST_DONE: begin
                d.is_rd = 1'b0;
                d.state = ST_IDLE;
            end
            default: d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.state == ST_IDLE);
    assign ack        = (q.state == ST_DONE);
    assign rd_valid   = (q.state == ST_DONE) && q.is_rd;
    assign rd_data    = q.rdata;
    assign mem_addr   = q.addr;
    assign mem_en_n   = q.en_n;
    assign mem_ce_n   = q.ce_n;
    assign mem_oe_n   = q.oe_n;
    assign mem_we_n   = q.we_n;
    assign mem_dq_oe  = q.dq_oe;
    assign mem_dq_out = q.wdata;

    AST_BUS_ONLY_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n)); // R5
    AST_STROBE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && !(&mem_en_n))); // R6
    AST_WRITE_ENDS_ON_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && !(&mem_en_n))); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R6
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R8
    AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n); // R8
    AST_RDV_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ack); // R3
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_dq_oe) |-> mem_oe_n); // R9
    AST_EMPTY_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && (&req_en_n)) |=> (mem_ce_n && ack)); // R7

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 18,
    parameter int unsigned CLK_PERIOD_NS = 5,
    parameter int unsigned POWERUP_NS    = 100000,
    parameter int unsigned T_CYC_RD_NS   = 10,
    parameter int unsigned T_ADDR_ACC_NS = 10,
    parameter int unsigned T_OE_ACC_NS   = 5,
    parameter int unsigned T_LANE_ACC_NS = 5,
    parameter int unsigned T_CYC_WR_NS   = 10,
    parameter int unsigned T_WE_LOW_NS   = 7,
    parameter int unsigned T_SEL_END_NS  = 7,
    parameter int unsigned T_ADR_END_NS  = 7,
    parameter int unsigned T_LANE_END_NS = 7,
    parameter int unsigned T_DATA_SU_NS  = 6,
    parameter int unsigned T_ADR_SU_NS   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_mask,
    input  logic [15:0]       req_wdata,
    output logic              ack,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n,
    output logic [15:0]       sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [15:0]       sram_dq_in
);
    localparam int unsigned DATA_W = 16;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = DATA_W / LANE_W;

    localparam int unsigned PU_CYC = ns_to_cyc(POWERUP_NS, CLK_PERIOD_NS);
    localparam int unsigned RD_CYC = umax(
        umax(ns_to_cyc(T_CYC_RD_NS, CLK_PERIOD_NS), ns_to_cyc(T_ADDR_ACC_NS, CLK_PERIOD_NS)),
        umax(ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_NS), ns_to_cyc(T_LANE_ACC_NS, CLK_PERIOD_NS)));
    localparam int unsigned SU_CYC = ns_to_cyc(T_ADR_SU_NS, CLK_PERIOD_NS);
    localparam int unsigned PW_CYC = umax(
        umax(ns_to_cyc(T_WE_LOW_NS, CLK_PERIOD_NS), ns_to_cyc(T_DATA_SU_NS, CLK_PERIOD_NS)),
        umax(rest_cyc(ns_to_cyc(T_SEL_END_NS, CLK_PERIOD_NS), SU_CYC),
             umax(rest_cyc(ns_to_cyc(T_ADR_END_NS, CLK_PERIOD_NS), SU_CYC),
                  rest_cyc(ns_to_cyc(T_LANE_END_NS, CLK_PERIOD_NS), SU_CYC))));
    localparam int unsigned REC_CYC = rest_cyc(ns_to_cyc(T_CYC_WR_NS, CLK_PERIOD_NS),
                                               SU_CYC + PW_CYC);

    logic             pu_done;
    logic [LANES-1:0] req_en_n;
    logic [LANES-1:0] mem_en_n;
    logic [DATA_W-1:0] rd_masked;

    sram_ctl_powerup #(
        .PU_CYC (PU_CYC)
    ) u_pu (
        .clk     (clk),
        .rst_n   (rst_n),
        .pu_done (pu_done)
    );

    sram_ctl_lanes #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_lanes (
        .req_mask (req_mask),
        .req_en_n (req_en_n),
        .cur_en_n (mem_en_n),
        .raw      (sram_dq_in),
        .masked   (rd_masked)
    );

    sram_ctl_fsm #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .LANES   (LANES),
        .RD_CYC  (RD_CYC),
        .SU_CYC  (SU_CYC),
        .PW_CYC  (PW_CYC),
        .REC_CYC (REC_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pu_done    (pu_done),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_en_n   (req_en_n),
        .req_wdata  (req_wdata),
        .rd_masked  (rd_masked),
        .ack        (ack),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .mem_addr   (sram_addr),
        .mem_en_n   (mem_en_n),
        .mem_ce_n   (sram_ce_n),
        .mem_oe_n   (sram_oe_n),
        .mem_we_n   (sram_we_n),
        .mem_dq_oe  (sram_dq_oe),
        .mem_dq_out (sram_dq_out)
    );

    assign sram_ub_n = mem_en_n[1];
    assign sram_lb_n = mem_en_n[0];

    AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !pu_done |-> (!req_ready && sram_ce_n)); // R1

endmodule

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;
    localparam int unsigned AW     = 6;
    localparam int unsigned WORDS  = 1 << AW;
    localparam int unsigned PER_NS = 5;

    function automatic int unsigned cyc(input int unsigned ns);
        int unsigned c;
        c = (ns + PER_NS - 1) / PER_NS;
        return (c == 0) ? 1 : c;
    endfunction

    // Expected phase lengths from the default limits of the requirements
    localparam int unsigned E_PU  = cyc(100000);
    localparam int unsigned E_RD  = 2;
    localparam int unsigned E_SU  = 1;
    localparam int unsigned E_PW  = 2;
    localparam int unsigned E_REC = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_mask = '0;
    logic [15:0]   req_wdata = '0;
    logic          ack;
    logic          rd_valid;
    logic [15:0]   rd_data;
    logic [AW-1:0] sram_addr;
    logic          sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n;
    logic [15:0]   sram_dq_out;
    logic          sram_dq_oe;
    logic [15:0]   sram_dq_in;

    logic [15:0] mem    [WORDS];
    logic [15:0] shadow [WORDS];

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sram_ctl #(.ADDR_W(AW), .CLK_PERIOD_NS(PER_NS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_mask(req_mask),
        .req_wdata(req_wdata), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // Memory model: drives the whole word whenever selected with output enabled
    assign sram_dq_in = (!sram_ce_n && !sram_oe_n) ? mem[sram_addr] : 16'h0000;

    // Port monitor, sampled on the falling edge
    logic        prev_we_n = 1'b1;
    logic        prev_dq_oe = 1'b0;
    logic [15:0] prev_dq = '0;
    int we_run = 0, oe_run = 0, last_we = 0, last_oe = 0;
    int viol_bus = 0, viol_turn = 0, viol_end = 0, ce_low = 0;

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) begin
            if (!sram_ce_n) ce_low <= ce_low + 1;
            if (sram_dq_oe && (sram_we_n || !sram_oe_n)) viol_bus <= viol_bus + 1;
            if (prev_dq_oe && !sram_oe_n) viol_turn <= viol_turn + 1;
            if (!sram_we_n) we_run <= we_run + 1;
            if (!sram_oe_n) oe_run <= oe_run + 1;
            else if (oe_run != 0) begin last_oe <= oe_run; oe_run <= 0; end
            if (!prev_we_n && sram_we_n) begin
                last_we <= we_run;
                we_run  <= 0;
                if (sram_ce_n || (sram_ub_n && sram_lb_n) || !prev_dq_oe)
                    viol_end <= viol_end + 1;
                if (!sram_ce_n) begin
                    if (!sram_ub_n) mem[sram_addr][15:8] <= prev_dq[15:8];
                    if (!sram_lb_n) mem[sram_addr][7:0]  <= prev_dq[7:0];
                end
            end
            prev_we_n  <= sram_we_n;
            prev_dq_oe <= sram_dq_oe;
            prev_dq    <= sram_dq_out;
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic access(input logic wr, input int a, input logic [1:0] m,
                          input logic [15:0] wd, output int n,
                          output logic [15:0] rd, output logic rdv);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_mask  = m;
        req_wdata = wd;
        n = 0;
        rd = '0;
        rdv = 1'b0;
        while (n < 40) begin
            @(negedge clk);
            #1;
            n++;
            req_valid = 1'b0;
            if (ack) begin
                rd  = rd_data;
                rdv = rd_valid;
                break;
            end
        end
    endtask

    initial begin : watchdog
        #(150000 * PER_NS);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        int n;
        int ce0;
        logic [15:0] rd;
        logic rdv;
        for (int i = 0; i < WORDS; i++) mem[i] = 16'h0000;

        repeat (3) @(negedge clk);
        #1;
        // Reset state
        chk("R1", "ready in reset", int'(req_ready), 0);
        chk("R8", "ack in reset", int'(ack), 0);
        chk("R5", "bus drive in reset", int'(sram_dq_oe), 0);
        chk("R2", "select in reset", int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);

        // R1: power-up wait counted from reset release
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 1; k <= int'(E_PU) + 1; k++) begin
            @(negedge clk);
            #1;
            if (k == 1 || k == int'(E_PU))
                chk("R1", "ready before wait", int'(req_ready), 0);
            if (k == int'(E_PU) + 1)
                chk("R1", "ready after wait", int'(req_ready), 1);
        end

        // Fill every word with a full-width pattern
        for (int a = 0; a < int'(WORDS); a++) begin
            shadow[a] = 16'(a * 16'h0101) ^ 16'hA55A;
            access(1'b1, a, 2'b11, shadow[a], n, rd, rdv);
            chk("R4", "write latency", n, int'(E_SU + E_PW + E_REC + 1));
            chk("R4", "we low cycles", last_we, int'(E_PW));
            chk("R8", "ready while done", int'(req_ready), 0);
        end

        // Partial writes with a rotating mask, including the empty mask
        for (int a = 0; a < int'(WORDS); a++) begin
            logic [1:0]  m;
            logic [15:0] wd;
            m  = 2'(a % 4);
            wd = 16'(a * 16'h1357) ^ 16'h3C3C;
            ce0 = ce_low;
            access(1'b1, a, m, wd, n, rd, rdv);
            if (m[1]) shadow[a][15:8] = wd[15:8];
            if (m[0]) shadow[a][7:0]  = wd[7:0];
            if (m == 2'b00) begin
                chk("R7", "empty-mask latency", n, 1);
                chk("R7", "empty-mask select cycles", ce_low - ce0, 0);
            end else begin
                chk("R4", "partial write latency", n, int'(E_SU + E_PW + E_REC + 1));
            end
            chk("R3", "no rd_valid on write", int'(rdv), 0);
        end

        // Read back every word with a second rotating mask
        for (int a = 0; a < int'(WORDS); a++) begin
            logic [1:0]  m;
            logic [15:0] ex;
            m  = 2'((a / 4) % 4);
            ex = {m[1] ? shadow[a][15:8] : 8'h00, m[0] ? shadow[a][7:0] : 8'h00};
            ce0 = ce_low;
            access(1'b0, a, m, 16'hFFFF, n, rd, rdv);
            if (m == 2'b00) begin
                chk("R7", "empty-mask read latency", n, 1);
                chk("R7", "empty-mask read select", ce_low - ce0, 0);
                chk("R3", "no rd_valid on empty read", int'(rdv), 0);
            end else begin
                chk("R2", "read latency", n, int'(E_RD + 1));
                chk("R2", "oe low cycles", last_oe, int'(E_RD));
                chk("R3", "rd_valid", int'(rdv), 1);
                chk("R10", "merged read data", int'(rd), int'(ex));
            end
        end

        // Back-to-back write then read on the same word (bus turnaround)
        access(1'b1, 5, 2'b10, 16'hBEEF, n, rd, rdv);
        shadow[5][15:8] = 8'hBE;
        access(1'b0, 5, 2'b11, 16'h0000, n, rd, rdv);
        chk("R10", "write then read", int'(rd), int'(shadow[5]));
        @(negedge clk);
        #1;
        chk("R8", "ack single cycle", int'(ack), 0);
        chk("R8", "ready after done", int'(req_ready), 1);

        chk("R5", "bus drive violations", viol_bus, 0);
        chk("R9", "turnaround violations", viol_turn, 0);
        chk("R6", "write-end violations", viol_end, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule